// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches eight input-only pins and turns each one into a clean, debounced level and an optional interrupt. Every pin is passed through a two-flop synchronizer and then through a per-channel settling counter. The counter advances on a 1 ms tick pulse supplied from outside. A new level is accepted only after the synchronized pin has disagreed with the held level for a programmed number of ticks, from 1 to 4095 ms. The accepted levels of all channels are readable together as one word.

Each channel fires a level-style interrupt when its accepted level equals a programmable active level, but only while software has armed the channel. Firing uses up the arm, so one stable event produces one status bit, and software must arm the channel again before the next event. Status bits are gated by a per-channel interrupt enable and ORed into a single interrupt output. All control, status and debounce settings are reached through a flat 32-bit register port with a single-cycle write strobe and a combinational read.

Each channel's debounce logic is a small state machine with three states. OFF means the channel is disabled and its synchronizer is frozen. STABLE means the input agrees with the held level. SETTLE means a disagreement is being timed. The transitions are as follows. Enable-on goes from OFF to STABLE. Disable goes from STABLE or SETTLE to OFF. Mismatch-seen goes from STABLE to SETTLE when the synchronized pin differs from the held level. Bounce-back goes from SETTLE to STABLE when the pin returns to the held level before the count ends; the count is dropped. Count-done goes from SETTLE to STABLE on the tick that completes the programmed count, and the new level is taken at that point.

Top module: `extint_debounce_bank`

## Requirements
- R1: A channel whose enable bit (register 0x04, bit n for channel n) is 0 does not sample its pin, and its accepted level holds while it stays disabled; once enabled, it samples again.
- R2: The accepted level changes only at a tick, after the synchronized pin has differed from it for N consecutive ticks. N is bits 11:0 of the channel's debounce word. A return to the held level before the count ends restarts the count.
- R3: A debounce setting of 0 behaves as a setting of 1 tick.
- R4: Register 0x00 returns the accepted level of channel n in bit n, and all levels are 0 after reset.
- R5: When channel n is armed (register 0x1C bit n) and its accepted level equals its active-level bit (register 0x08; 1 = high is active, 0 = low is active), raw status bit n (register 0x10) is set one cycle later and the arm bit is cleared.
- R6: A channel that is not armed never sets its raw status bit. After firing, it stays silent until software writes its arm bit to 1 again.
- R7: The masked status (register 0x14) equals raw status AND interrupt enable (register 0x0C), and irq_out is the OR of the masked status bits.
- R8: Writing 1 to bit n of the clear register (0x18) clears raw bit n. If a fire coincides with that write, the clear wins: raw stays 0 and the arm bit is kept.
- R9: The debounce word of channel n sits at 0x20 + 4n and reads back all 32 bits as written. The enable, active-level, interrupt-enable and arm registers read back as written. The clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| pin_in | input | 8 | Asynchronous input pins, bit n = channel n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_out | output | 1 | Combined interrupt |

## Verification
The pins are driven with four patterns. A clean step tells a working settling count apart from an instant pass-through. A step on a channel programmed to 0 separates the one-tick floor from a 4096-tick wrap. Repeated pulses shorter than the programmed count show that a bounce restarts the count and is not added up. A step on a disabled channel shows that the synchronizer is frozen. On the interrupt side, firing on both the active-high and active-low settings, firing with and without the enable, and a clear that collides with a pending fire tell the arm-consumption rule apart from the clear-priority rule. A behavioural model in the bench is compared with the read port and irq_out on every cycle.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] REG_LEVEL  = 8'h00;
    localparam logic [ADDR_W-1:0] REG_ENABLE = 8'h04;
    localparam logic [ADDR_W-1:0] REG_POL    = 8'h08;
    localparam logic [ADDR_W-1:0] REG_IE     = 8'h0C;
    localparam logic [ADDR_W-1:0] REG_RAW    = 8'h10;
    localparam logic [ADDR_W-1:0] REG_MASKED = 8'h14;
    localparam logic [ADDR_W-1:0] REG_CLR    = 8'h18;
    localparam logic [ADDR_W-1:0] REG_ARM    = 8'h1C;
    localparam logic [ADDR_W-1:0] REG_DBNC   = 8'h20;

    typedef enum logic [1:0] {
        DB_OFF    = 2'd0,
        DB_STABLE = 2'd1,
        DB_SETTLE = 2'd2
    } db_state_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shift_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n)    shift_q <= '0;
                else if (en_i) shift_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n)    shift_q <= '0;
                else if (en_i) shift_q <= {shift_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/extint_dbnc_chan.sv
module extint_dbnc_chan
    import extint_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             level_o
);
    db_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_eff;
    logic [CNT_W:0]   cnt_inc;
    logic             count_done;
    logic             take;
    logic             level_q;

    assign lim_eff    = (limit_i == '0) ? CNT_W'(1) : limit_i;
    assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
    assign count_done = tick_i && (cnt_inc >= {1'b0, lim_eff});

    // next state: enable-on, disable, mismatch-seen, bounce-back, count-done
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            DB_OFF: begin
                if (en_i) state_d = DB_STABLE;
            end
            DB_STABLE: begin
                if (!en_i)                  state_d = DB_OFF;
                else if (sync_i != level_q) state_d = DB_SETTLE;
            end
            DB_SETTLE: begin
                if (!en_i)                  state_d = DB_OFF;
                else if (sync_i == level_q) state_d = DB_STABLE;
                else if (count_done) begin
                    state_d = DB_STABLE;
                    take    = 1'b1;
                end
            end
            default: state_d = DB_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DB_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else begin
            if (state_d != DB_SETTLE)                  cnt_q <= '0;
            else if (state_q == DB_SETTLE && tick_i)   cnt_q <= cnt_inc[CNT_W-1:0];
            if (take) level_q <= sync_i;
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/extint_irq_slice.sv
module extint_irq_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic pol_i,
    input  logic clr_i,
    input  logic arm_wr_i,
    input  logic arm_wdata_i,
    output logic raw_o,
    output logic arm_o
);
    logic raw_q, arm_q, fire;

    // a clear in the same cycle blocks the fire, so the arm survives
    assign fire = arm_q && (level_i == pol_i) && !clr_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            if (clr_i)     raw_q <= 1'b0;
            else if (fire) raw_q <= 1'b1;
            if (arm_wr_i)  arm_q <= arm_wdata_i;
            else if (fire) arm_q <= 1'b0;
        end
    end

    assign raw_o = raw_q;
    assign arm_o = arm_q;
endmodule

// File: rtl/extint_debounce_bank.sv
module extint_debounce_bank
    import extint_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    localparam int PAD_W = DATA_W - NUM_CH;

    logic [NUM_CH-1:0] en_q, pol_q, ie_q;
    logic [NUM_CH-1:0] level_w, raw_w, arm_w, clr_w, sync_w;
    logic [DATA_W-1:0] dbnc_q [NUM_CH];
    logic              wr_arm;

    assign wr_arm = reg_wr && (reg_addr == REG_ARM);
    assign clr_w  = (reg_wr && reg_addr == REG_CLR) ? reg_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
            ie_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == REG_ENABLE) en_q  <= reg_wdata[NUM_CH-1:0];
            if (reg_addr == REG_POL)    pol_q <= reg_wdata[NUM_CH-1:0];
            if (reg_addr == REG_IE)     ie_q  <= reg_wdata[NUM_CH-1:0];
        end
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            localparam logic [ADDR_W-1:0] MY_ADDR = REG_DBNC + ADDR_W'(4 * ch);

            always_ff @(posedge clk) begin
                if (!rst_n)                             dbnc_q[ch] <= '0;
                else if (reg_wr && reg_addr == MY_ADDR) dbnc_q[ch] <= reg_wdata;
            end

            extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (en_q[ch]),
                .d_i   (pin_in[ch]),
                .q_o   (sync_w[ch])
            );

            extint_dbnc_chan #(.CNT_W(CNT_W)) u_dbnc (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_i    (en_q[ch]),
                .tick_i  (tick_1ms),
                .sync_i  (sync_w[ch]),
                .limit_i (dbnc_q[ch][CNT_W-1:0]),
                .level_o (level_w[ch])
            );

            extint_irq_slice u_irq (
                .clk         (clk),
                .rst_n       (rst_n),
                .level_i     (level_w[ch]),
                .pol_i       (pol_q[ch]),
                .clr_i       (clr_w[ch]),
                .arm_wr_i    (wr_arm),
                .arm_wdata_i (reg_wdata[ch]),
                .raw_o       (raw_w[ch]),
                .arm_o       (arm_w[ch])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_LEVEL:  reg_rdata = {{PAD_W{1'b0}}, level_w};
            REG_ENABLE: reg_rdata = {{PAD_W{1'b0}}, en_q};
            REG_POL:    reg_rdata = {{PAD_W{1'b0}}, pol_q};
            REG_IE:     reg_rdata = {{PAD_W{1'b0}}, ie_q};
            REG_RAW:    reg_rdata = {{PAD_W{1'b0}}, raw_w};
            REG_MASKED: reg_rdata = {{PAD_W{1'b0}}, raw_w & ie_q};
            REG_ARM:    reg_rdata = {{PAD_W{1'b0}}, arm_w};
            default:    reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == REG_DBNC + ADDR_W'(4 * i)) reg_rdata = dbnc_q[i];
        end
    end

    assign irq_out = |(raw_w & ie_q);
endmodule

// File: rtl/extint_chk.sv
module extint_chk
    import extint_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1ms,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_out,
    input logic [NUM_CH-1:0] level_i,
    input logic [NUM_CH-1:0] raw_i,
    input logic [NUM_CH-1:0] arm_i,
    input logic [NUM_CH-1:0] en_i,
    input logic [NUM_CH-1:0] ie_i
);
    logic arm_wr_c;
    assign arm_wr_c = reg_wr && (reg_addr == REG_ARM);

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (ie_i != '0)); // R7

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_a
            AST_RAW_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(raw_i[i]) |-> $past(arm_i[i])); // R6
            AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(raw_i[i]) && !$past(arm_wr_c)) |-> !arm_i[i]); // R5
            AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && reg_addr == REG_CLR && reg_wdata[i]) |=> !raw_i[i]); // R8
            AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(level_i[i]) |-> $past(tick_1ms)); // R2
            AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                !en_i[i] |=> $stable(level_i[i])); // R1
        end
    endgenerate
endmodule

bind extint_debounce_bank extint_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1ms  (tick_1ms),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .level_i   (level_w),
    .raw_i     (raw_w),
    .arm_i     (arm_w),
    .en_i      (en_q),
    .ie_i      (ie_q)
);

// File: tb/extint_debounce_bank_tb_top.sv
module extint_debounce_bank_tb_top;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1ms = 1'b0;
    logic [7:0]  pin_in = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit running = 0;
    bit done = 0;

    always #10 clk = ~clk;

    extint_debounce_bank dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pin_in(pin_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // tick every 4 cycles, changed away from the active edge
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        tick_1ms = (tick_div == 0);
    end

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_en = '0, m_pol = '0, m_ie = '0, m_raw = '0, m_arm = '0, m_lvl = '0;
    logic [7:0]  m_s1 = '0, m_s2 = '0;
    logic [31:0] m_dc [NCH];
    int          m_st [NCH];   // 0 off, 1 stable, 2 settling
    int          m_cnt [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_pol = '0; m_ie = '0; m_raw = '0; m_arm = '0; m_lvl = '0;
            m_s1 = '0; m_s2 = '0;
            for (int i = 0; i < NCH; i++) begin
                m_dc[i] = '0; m_st[i] = 0; m_cnt[i] = 0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                bit clr, fire, armw;
                int lim;
                clr  = reg_wr && reg_addr == 8'h18 && reg_wdata[i];
                armw = reg_wr && reg_addr == 8'h1C;
                fire = m_arm[i] && (m_lvl[i] == m_pol[i]) && !clr;
                if (clr) m_raw[i] = 1'b0; else if (fire) m_raw[i] = 1'b1;
                if (armw) m_arm[i] = reg_wdata[i]; else if (fire) m_arm[i] = 1'b0;
                lim = (m_dc[i][11:0] == 0) ? 1 : int'(m_dc[i][11:0]);
                case (m_st[i])
                    0: if (m_en[i]) m_st[i] = 1;
                    1: begin
                        if (!m_en[i]) m_st[i] = 0;
                        else if (m_s2[i] != m_lvl[i]) begin m_st[i] = 2; m_cnt[i] = 0; end
                    end
                    default: begin
                        if (!m_en[i]) begin m_st[i] = 0; m_cnt[i] = 0; end
                        else if (m_s2[i] == m_lvl[i]) begin m_st[i] = 1; m_cnt[i] = 0; end
                        else if (tick_1ms) begin
                            if (m_cnt[i] + 1 >= lim) begin
                                m_lvl[i] = m_s2[i]; m_st[i] = 1; m_cnt[i] = 0;
                            end else m_cnt[i] = m_cnt[i] + 1;
                        end
                    end
                endcase
                if (m_en[i]) begin m_s2[i] = m_s1[i]; m_s1[i] = pin_in[i]; end
            end
            if (reg_wr) begin
                case (reg_addr)
                    8'h04: m_en  = reg_wdata[7:0];
                    8'h08: m_pol = reg_wdata[7:0];
                    8'h0C: m_ie  = reg_wdata[7:0];
                    default: ;
                endcase
                for (int i = 0; i < NCH; i++)
                    if (reg_addr == 8'h20 + 8'(4 * i)) m_dc[i] = reg_wdata;
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            8'h00: r = {24'b0, m_lvl};
            8'h04: r = {24'b0, m_en};
            8'h08: r = {24'b0, m_pol};
            8'h0C: r = {24'b0, m_ie};
            8'h10: r = {24'b0, m_raw};
            8'h14: r = {24'b0, m_raw & m_ie};
            8'h1C: r = {24'b0, m_arm};
            default: ;
        endcase
        for (int i = 0; i < NCH; i++)
            if (a == 8'h20 + 8'(4 * i)) r = m_dc[i];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R4, R7, R9)
    always @(negedge clk) begin
        if (running) begin
            #2;
            chk("R4/R9 per-cycle read", reg_rdata, model_read(reg_addr));
            chk("R7 per-cycle irq", {31'b0, irq_out}, {31'b0, |(m_raw & m_ie)});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #3;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        running = 1;
        rd("R4 reset level", 8'h00, 32'h0);
        rd("R7 reset raw", 8'h10, 32'h0);
        chk("R7 reset irq", {31'b0, irq_out}, 32'h0);

        wr(8'h20, 32'd3);
        wr(8'h24, 32'd0);
        wr(8'h28, 32'd5);
        wr(8'h2C, 32'd2);
        wr(8'h30, 32'd2);
        wr(8'h34, 32'hABCD_E002);
        wr(8'h38, 32'd2);
        wr(8'h3C, 32'd2);
        rd("R9 debounce word readback", 8'h34, 32'hABCD_E002);
        wr(8'h04, 32'h7F);
        rd("R9 enable readback", 8'h04, 32'h7F);

        pin_in = 8'h01; wait_cyc(60);
        rd("R2 clean step ch0", 8'h00, 32'h01);
        pin_in = 8'h03; wait_cyc(20);
        rd("R3 zero setting ch1", 8'h00, 32'h03);

        for (int k = 0; k < 5; k++) begin
            pin_in[2] = 1'b1; wait_cyc(8);
            pin_in[2] = 1'b0; wait_cyc(8);
        end
        wait_cyc(30);
        rd("R2 bounce rejected ch2", 8'h00, 32'h03);
        pin_in[2] = 1'b1; wait_cyc(60);
        rd("R2 held step ch2", 8'h00, 32'h07);

        pin_in[7] = 1'b1; wait_cyc(60);
        rd("R1 disabled ch7 holds", 8'h00, 32'h07);
        wr(8'h04, 32'hFF); wait_cyc(60);
        rd("R1 enabled ch7 samples", 8'h00, 32'h87);

        wr(8'h08, 32'h01);
        wr(8'h0C, 32'h01);
        wr(8'h1C, 32'h01);
        wait_cyc(2);
        rd("R5 high-active fire raw", 8'h10, 32'h01);
        rd("R5 arm consumed", 8'h1C, 32'h00);
        rd("R7 masked", 8'h14, 32'h01);
        chk("R7 irq high", {31'b0, irq_out}, 32'h1);

        wr(8'h18, 32'h01);
        rd("R8 clear raw", 8'h10, 32'h00);
        chk("R8 irq low after clear", {31'b0, irq_out}, 32'h0);
        wait_cyc(10);
        rd("R6 no refire without arm", 8'h10, 32'h00);

        wr(8'h1C, 32'h08);
        wait_cyc(2);
        rd("R5 low-active fire raw", 8'h10, 32'h08);
        rd("R7 masked gated by enable", 8'h14, 32'h00);
        chk("R7 irq gated", {31'b0, irq_out}, 32'h0);

        wr(8'h18, 32'h08);
        wr(8'h1C, 32'h08);
        wr(8'h18, 32'h08);
        rd("R8 clear wins, arm kept", 8'h1C, 32'h08);
        rd("R8 clear wins, raw low", 8'h10, 32'h00);
        wait_cyc(1);
        rd("R5 fires after collision", 8'h10, 32'h08);
        rd("R5 arm consumed after collision", 8'h1C, 32'h00);

        wr(8'h0C, 32'h09);
        rd("R7 masked ch3", 8'h14, 32'h08);
        chk("R7 irq ch3", {31'b0, irq_out}, 32'h1);
        wr(8'h1C, 32'h01);
        wait_cyc(1);
        rd("R6 rearm refires ch0", 8'h10, 32'h09);
        rd("R7 masked both", 8'h14, 32'h09);
        wr(8'h18, 32'hFF);
        rd("R8 clear all", 8'h14, 32'h00);
        chk("R8 irq low", {31'b0, irq_out}, 32'h0);
        rd("R9 clear reads zero", 8'h18, 32'h00);

        wait_cyc(2);
        running = 0;
        done = 1;
        report();
    end
endmodule